// File: doc/BRIEF.md
# Audio DAC Input Source Selector

This block decides which stereo sample stream reaches the DAC path. Two external serial inputs, already deserialised into parallel 24-bit left/right pairs, compete for the path. A loopback mode can replace both of them with the ADC's own sample stream. Each stream delivers one left/right pair per transfer with a valid/ready handshake. The block holds the chosen pair in a single output register, and the DAC path drains that register through its own valid/ready handshake.

The block also produces the interface-format code that the DAC path should use. While loopback is on, that code is frozen: edits to the format control are ignored until loopback ends, and then the control's current value applies. A clock-change pulse forces the DAC into silence. Any pair still waiting in the output register is zeroed. The pair taken in the pulse cycle is zeroed, and so is a programmable number of pairs after it.

Back-pressure follows the usual rules. An offered pair stays on the output, unchanged, until `out_ready` is seen high at a clock edge; the one exception is the zeroing by a clock change. The selected source sees ready only when the output register is empty or being drained in that cycle. Streams that are not selected are always ready, so their pairs are consumed and discarded and they never stall.

Top module: `adsel_top`

## Requirements
- R1: After reset, `out_valid`, `out_loop`, `out_fmt` and both output samples are zero, and source A is selected.
- R2: With loopback off and `sel_b` low, pairs from source A appear at the output one clock after their handshake, while `b_ready` and `adc_ready` stay high and their pairs are discarded.
- R3: With loopback off and `sel_b` high, pairs from source B are passed in the same way, while `a_ready` stays high and source A pairs are discarded.
- R4: With `loop_en` high, ADC pairs are passed whatever `sel_b` holds, and `a_ready` and `b_ready` are both high.
- R5: `sel_b` and `loop_en` are registered, so a change applies from the clock after it is sampled. Every transfer carries a whole pair from a single source.
- R6: With loopback off, `out_fmt` equals the `dac_fmt` value sampled at the previous clock.
- R7: While loopback is active, `out_fmt` keeps the value it had when loopback began, and changes to `dac_fmt` have no effect on it.
- R8: When loopback is cleared, `out_fmt` takes the value `dac_fmt` holds at that moment.
- R9: While `out_valid` is high and `out_ready` is low, the output pair and `out_valid` hold steady and the selected source's ready is low, unless a clock change zeroes the pair.
- R10: A one-cycle `clk_change` pulse zeroes a pair held in the output register, and also a pair taken in the same cycle.
- R11: After the pulse, the next `mute_len` pairs taken are output as zero, and then real data resumes.
- R12: A `clk_change` pulse during a mute restarts the count at `mute_len`.
- R13: `out_loop` is high exactly while the registered loopback control is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_valid | input | 1 | Source A pair valid |
| a_ready | output | 1 | Source A ready |
| a_left | input | 24 | Source A left sample |
| a_right | input | 24 | Source A right sample |
| b_valid | input | 1 | Source B pair valid |
| b_ready | output | 1 | Source B ready |
| b_left | input | 24 | Source B left sample |
| b_right | input | 24 | Source B right sample |
| adc_valid | input | 1 | ADC pair valid |
| adc_ready | output | 1 | ADC ready |
| adc_left | input | 24 | ADC left sample |
| adc_right | input | 24 | ADC right sample |
| sel_b | input | 1 | 0 selects source A, 1 selects source B |
| loop_en | input | 1 | Route ADC pairs to the DAC path |
| dac_fmt | input | 2 | Requested DAC interface-format code |
| mute_len | input | 4 | Number of zero pairs after a clock change |
| clk_change | input | 1 | One-cycle clock-change pulse |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | DAC path accepts the pair |
| out_left | output | 24 | Output left sample |
| out_right | output | 24 | Output right sample |
| out_fmt | output | 2 | Effective DAC format code |
| out_loop | output | 1 | Loopback active |

## Verification
The hardest case to reach is a clock-change pulse that lands while a non-zero pair is stalled in the output register. The bench sets up this case deliberately. It holds `out_ready` low, loads a pair, fires the pulse, and only then releases the DAC side, expecting a zero pair. A second hard case is a pulse in the middle of a mute, which should restart the count. The bench sends part of a mute sequence, pulses again, and checks that the count restarts. The frozen-format behaviour is checked by editing `dac_fmt` during loopback and then clearing loopback with yet another value present.

// File: rtl/adsel_pkg.sv
package adsel_pkg;
  localparam int FMT_W = 2;
  localparam int NSRC  = 3;

  typedef enum logic [1:0] {
    SRC_A   = 2'd0,
    SRC_B   = 2'd1,
    SRC_ADC = 2'd2
  } src_e;
endpackage

// File: rtl/adsel_cfg.sv
module adsel_cfg
  import adsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_b,
  input  logic             loop_en,
  input  logic [FMT_W-1:0] dac_fmt,
  output src_e             src,
  output logic             loop_q,
  output logic [FMT_W-1:0] fmt_eff
);
  logic sel_q;

  // Control bits are registered; a transfer always uses one settled source.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      loop_q  <= 1'b0;
      fmt_eff <= '0;
    end else begin
      sel_q  <= sel_b;
      loop_q <= loop_en;
      // Format is frozen while loopback is requested.
      if (!loop_en) fmt_eff <= dac_fmt;
    end
  end

  always_comb begin
    if (loop_q)     src = SRC_ADC;
    else if (sel_q) src = SRC_B;
    else            src = SRC_A;
  end
endmodule

// File: rtl/adsel_mute.sv
module adsel_mute #(
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_change,
  input  logic [MW-1:0] mute_len,
  input  logic          take,
  output logic          zero_now,
  output logic          mute_active
);
  logic [MW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clk_change)        cnt <= mute_len;
    else if (take && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign mute_active = (cnt != '0);
  assign zero_now    = clk_change || mute_active;
endmodule

// File: rtl/adsel_mux.sv
module adsel_mux
  import adsel_pkg::*;
#(
  parameter int SW = 24
) (
  input  src_e                src,
  input  logic [NSRC-1:0]     in_valid,
  input  logic [NSRC*SW-1:0]  in_left,
  input  logic [NSRC*SW-1:0]  in_right,
  input  logic                take_ok,
  output logic [NSRC-1:0]     in_ready,
  output logic                sel_valid,
  output logic [SW-1:0]       sel_left,
  output logic [SW-1:0]       sel_right
);
  // Unselected streams are drained so they never stall.
  for (genvar i = 0; i < NSRC; i++) begin : g_rdy
    assign in_ready[i] = (int'(src) == i) ? take_ok : 1'b1;
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_left  = '0;
    sel_right = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (int'(src) == i) begin
        sel_valid = in_valid[i];
        sel_left  = in_left[i*SW +: SW];
        sel_right = in_right[i*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/adsel_out.sv
module adsel_out #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          zero,
  input  logic          clear_held,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  input  logic          out_ready,
  output logic          take_ok,
  output logic          out_valid,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right
);
  assign take_ok = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_left  <= zero ? '0 : in_left;
      out_right <= zero ? '0 : in_right;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (clear_held) begin
        out_left  <= '0;
        out_right <= '0;
      end
    end
  end
endmodule

// File: rtl/adsel_top.sv
module adsel_top
  import adsel_pkg::*;
#(
  parameter int SW = 24,
  parameter int MW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [SW-1:0]    a_left,
  input  logic [SW-1:0]    a_right,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [SW-1:0]    b_left,
  input  logic [SW-1:0]    b_right,
  input  logic             adc_valid,
  output logic             adc_ready,
  input  logic [SW-1:0]    adc_left,
  input  logic [SW-1:0]    adc_right,
  input  logic             sel_b,
  input  logic             loop_en,
  input  logic [FMT_W-1:0] dac_fmt,
  input  logic [MW-1:0]    mute_len,
  input  logic             clk_change,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SW-1:0]    out_left,
  output logic [SW-1:0]    out_right,
  output logic [FMT_W-1:0] out_fmt,
  output logic             out_loop
);
  src_e               src;
  logic               take_ok;
  logic               sel_valid;
  logic [SW-1:0]      sel_left;
  logic [SW-1:0]      sel_right;
  logic [NSRC-1:0]    in_ready;
  logic               load;
  logic               zero_now;
  logic               mute_active;

  adsel_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .sel_b(sel_b), .loop_en(loop_en),
    .dac_fmt(dac_fmt), .src(src), .loop_q(out_loop), .fmt_eff(out_fmt)
  );

  adsel_mux #(.SW(SW)) u_mux (
    .src(src),
    .in_valid({adc_valid, b_valid, a_valid}),
    .in_left({adc_left, b_left, a_left}),
    .in_right({adc_right, b_right, a_right}),
    .take_ok(take_ok), .in_ready(in_ready),
    .sel_valid(sel_valid), .sel_left(sel_left), .sel_right(sel_right)
  );

  assign a_ready   = in_ready[SRC_A];
  assign b_ready   = in_ready[SRC_B];
  assign adc_ready = in_ready[SRC_ADC];
  assign load      = sel_valid && take_ok;

  adsel_mute #(.MW(MW)) u_mute (
    .clk(clk), .rst_n(rst_n), .clk_change(clk_change), .mute_len(mute_len),
    .take(load), .zero_now(zero_now), .mute_active(mute_active)
  );

  adsel_out #(.SW(SW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .zero(zero_now),
    .clear_held(clk_change), .in_left(sel_left), .in_right(sel_right),
    .out_ready(out_ready), .take_ok(take_ok), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );
endmodule

// File: rtl/adsel_chk.sv
module adsel_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_ready,
  input logic          b_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_left,
  input logic [SW-1:0] out_right,
  input logic [1:0]    out_fmt,
  input logic          out_loop,
  input logic          clk_change,
  input logic          mute_active,
  input logic          load
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clk_change) |=>
      (out_valid && $stable(out_left) && $stable(out_right)));

  assert_fmt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_loop |-> $stable(out_fmt));

  assert_loop_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_loop |-> (a_ready && b_ready));

  assert_clkchg_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_change |=> (out_left == '0 && out_right == '0));

  assert_mute_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_active && load) |=> (out_left == '0 && out_right == '0));
endmodule

bind adsel_top adsel_chk #(.SW(SW)) u_chk (.*);

// File: tb/sim_adsel_top.sv
module sim_adsel_top;
  localparam int SW = 24;

  typedef struct {
    logic [SW-1:0] l;
    logic [SW-1:0] r;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 0, b_valid = 0, adc_valid = 0;
  logic a_ready, b_ready, adc_ready;
  logic [SW-1:0] a_left = '0, a_right = '0, b_left = '0, b_right = '0;
  logic [SW-1:0] adc_left = '0, adc_right = '0;
  logic sel_b = 0, loop_en = 0, clk_change = 0, out_ready = 1;
  logic [1:0] dac_fmt = '0;
  logic [3:0] mute_len = '0;
  logic out_valid, out_loop;
  logic [SW-1:0] out_left, out_right;
  logic [1:0] out_fmt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  adsel_top u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_left(a_left), .a_right(a_right),
    .b_valid(b_valid), .b_ready(b_ready), .b_left(b_left), .b_right(b_right),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .adc_left(adc_left), .adc_right(adc_right),
    .sel_b(sel_b), .loop_en(loop_en), .dac_fmt(dac_fmt), .mute_len(mute_len),
    .clk_change(clk_change), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right), .out_fmt(out_fmt), .out_loop(out_loop)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: offers one pair on a source and queues the expected output.
  task automatic send(input int src, input logic [SW-1:0] l, input logic [SW-1:0] r,
                      input bit expect_out, input logic [SW-1:0] el,
                      input logic [SW-1:0] er, input string req);
    bit ok;
    exp_t e;
    if (expect_out) begin
      e.l = el; e.r = er; e.req = req;
      q.push_back(e);
    end
    case (src)
      0: begin a_valid = 1; a_left = l; a_right = r; end
      1: begin b_valid = 1; b_left = l; b_right = r; end
      default: begin adc_valid = 1; adc_left = l; adc_right = r; end
    endcase
    do begin
      #2;
      ok = (src == 0) ? a_ready : (src == 1) ? b_ready : adc_ready;
      @(negedge clk);
    end while (!ok);
    a_valid = 0; b_valid = 0; adc_valid = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops and compares each pair the DAC side accepts.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(0, "R2 unexpected output", longint'(out_left), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_left == e.l && out_right == e.r, e.req,
              longint'({out_left, out_right}), longint'({e.l, e.r}));
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    #2;
    chk(out_valid == 0 && out_loop == 0 && out_fmt == 0 && out_left == 0, "R1 reset",
        longint'({out_valid, out_loop, out_fmt}), 0);
    @(negedge clk);
    rst_n = 1;
    cyc(2);

    // R2: source A selected
    send(0, 24'h000101, 24'h000102, 1, 24'h000101, 24'h000102, "R2 src A");
    send(0, 24'hFFFFFE, 24'h800000, 1, 24'hFFFFFE, 24'h800000, "R2 src A neg");
    chk(b_ready == 1 && adc_ready == 1, "R2 drain B", longint'({b_ready, adc_ready}), 3);
    send(1, 24'h0BAD00, 24'h0BAD01, 0, '0, '0, "R2");

    // R5/R3: switch to B, applies from the next clock
    sel_b = 1;
    @(negedge clk);
    send(1, 24'h0B0001, 24'h0B0002, 1, 24'h0B0001, 24'h0B0002, "R5 switch to B");
    send(1, 24'h7FFFFF, 24'h000000, 1, 24'h7FFFFF, 24'h000000, "R3 src B");
    #2;
    chk(a_ready == 1, "R3 drain A", longint'(a_ready), 1);
    @(negedge clk);
    send(0, 24'h0BAD02, 24'h0BAD03, 0, '0, '0, "R3");

    // R6: format follows
    dac_fmt = 2'd2;
    @(negedge clk);
    #2;
    chk(out_fmt == 2'd2, "R6 fmt follows", longint'(out_fmt), 2);
    @(negedge clk);

    // R4/R13/R7: loopback
    loop_en = 1;
    @(negedge clk);
    dac_fmt = 2'd1;
    #2;
    chk(out_loop == 1, "R13 loop flag", longint'(out_loop), 1);
    chk(a_ready && b_ready, "R4 drain A/B", longint'({a_ready, b_ready}), 3);
    @(negedge clk);
    send(2, 24'h0ADC01, 24'h0ADC02, 1, 24'h0ADC01, 24'h0ADC02, "R4 loopback ADC");
    send(1, 24'h0BAD04, 24'h0BAD05, 0, '0, '0, "R4");
    cyc(2);
    #2;
    chk(out_fmt == 2'd2, "R7 fmt frozen", longint'(out_fmt), 2);
    @(negedge clk);

    // R8: clear loopback with a third value present
    dac_fmt = 2'd3;
    loop_en = 0;
    @(negedge clk);
    #2;
    chk(out_fmt == 2'd3, "R8 fmt after loop", longint'(out_fmt), 3);
    chk(out_loop == 0, "R13 loop cleared", longint'(out_loop), 0);
    @(negedge clk);

    // R9: back-pressure
    out_ready = 0;
    send(1, 24'h090001, 24'h090002, 1, 24'h090001, 24'h090002, "R9 held pair");
    cyc(3);
    #2;
    chk(out_valid == 1 && out_left == 24'h090001, "R9 hold", longint'(out_left), 24'h090001);
    chk(b_ready == 0, "R9 source stalled", longint'(b_ready), 0);
    @(negedge clk);
    out_ready = 1;
    cyc(2);

    // R10: clock change zeroes a stalled pair
    mute_len = 4'd0;
    out_ready = 0;
    send(1, 24'h0A0A0A, 24'h050505, 1, '0, '0, "R10 held pair zeroed");
    clk_change = 1;
    @(negedge clk);
    clk_change = 0;
    #2;
    chk(out_left == 0 && out_right == 0, "R10 zero now", longint'(out_left), 0);
    @(negedge clk);
    out_ready = 1;
    cyc(2);

    // R11: mute for four pairs
    mute_len = 4'd4;
    clk_change = 1;
    @(negedge clk);
    clk_change = 0;
    for (int i = 0; i < 4; i++)
      send(1, 24'h111111 + i, 24'h222222, 1, '0, '0, "R11 muted pair");
    send(1, 24'h333333, 24'h444444, 1, 24'h333333, 24'h444444, "R11 resume");

    // R12: restart mute mid-sequence
    mute_len = 4'd3;
    clk_change = 1;
    @(negedge clk);
    clk_change = 0;
    send(1, 24'h010101, 24'h020202, 1, '0, '0, "R12 muted before restart");
    send(1, 24'h010102, 24'h020203, 1, '0, '0, "R12 muted before restart");
    clk_change = 1;
    @(negedge clk);
    clk_change = 0;
    for (int i = 0; i < 3; i++)
      send(1, 24'h050500 + i, 24'h060600, 1, '0, '0, "R12 muted after restart");
    send(1, 24'h0C0C0C, 24'h0D0D0D, 1, 24'h0C0C0C, 24'h0D0D0D, "R12 resume");

    cyc(4);
    chk(q.size() == 0, "R5 all pairs delivered", longint'(q.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule